// File: doc/BRIEF.md
# Synchronous Byte Serial Link Port

This block moves one byte at a time between two devices over three wires: a data line out, a data line in and a shared shift clock. A single 8-bit data register is both the byte to send and the place where the received byte collects, so after a transfer the register holds what the peer sent. A control write starts a transfer and picks the clock master. When the port is master, it drives the shared clock line from a divider of the system clock. When the port is slave, it follows edges that the peer puts on that line, after passing them through a synchroniser.

Bits leave and arrive most significant first. The outgoing bit changes when the shift clock falls, and the incoming bit is taken when the clock rises. After the eighth rising edge the busy flag drops and a one-cycle interrupt request pulse is raised. The last bit sent stays on the output line until the next transfer starts. If the port is master and nothing drives the input line, that line floats high, so the received byte reads as all ones.

The port is built around a five-state controller. `ST_IDLE` waits for a start. A start with the internal clock goes to `ST_INT_LOW`; a start with the external clock goes to `ST_EXT_WAIT_FALL`. The `ST_INT_LOW` and `ST_INT_HIGH` states alternate, each lasting half a divider period. The `ST_EXT_WAIT_FALL` and `ST_EXT_WAIT_RISE` states alternate on the peer's edges. After the eighth sample, either `ST_INT_LOW` or `ST_EXT_WAIT_RISE` returns to `ST_IDLE`.

Top module: `link_shift_port`

## Requirements
- R1: After reset, `data_q` is 0x00, `busy`, `xfer_irq`, `sck_oe` and `clk_internal` are 0, and `ser_out` and `sck_out` are 1.
- R2: A control write while idle, with bit 7 set, starts a transfer, and `busy` reads 1 from the next cycle. Bit 0 of the same write selects the clock source and is shown on `clk_internal`: 1 means internal and 0 means external. A control write while idle with bit 7 clear only updates the clock source and starts nothing.
- R3: With the internal clock, `sck_oe` is 1 for the whole transfer. `sck_out` goes low exactly eight times, and every low phase and every high phase lasts CLK_DIV/2 cycles. Outside an internal transfer, `sck_oe` is 0 and `sck_out` is 1.
- R4: `ser_out` changes only at a falling edge of the shift clock, and it presents the data register bits from bit 7 down to bit 0.
- R5: At each rising edge of the shift clock, the input bit shifts into bit 0 of the data register, so after eight bits the register holds the peer's byte, most significant bit first.
- R6: With the internal clock, `busy` falls and `xfer_irq` pulses for exactly one cycle. Counted from the clock edge that takes the start write, this happens at edge 15*CLK_DIV/2.
- R7: An internally clocked transfer with `ser_in` held high leaves 0xFF in the data register.
- R8: After a transfer, `ser_out` keeps holding the last bit sent (bit 0 of the original byte) while the port is idle.
- R9: With the external clock, `sck_oe` stays 0 and the port waits for the peer's edges without a time limit. It completes on the eighth synchronised rising edge of `sck_in`, with the same data results as R4 and R5.
- R10: While `busy` is 1, writes to the data register and to the control register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr_en | input | 1 | Data register write strobe |
| data_wr | input | 8 | Data register write value |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr | input | 8 | Control write value: bit 7 is the start bit, bit 0 is the clock source (1 = internal) |
| data_q | output | 8 | Data register contents |
| busy | output | 1 | Transfer in progress (start bit readback) |
| clk_internal | output | 1 | Clock source currently selected |
| xfer_irq | output | 1 | One-cycle transfer-complete request |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |
| sck_out | output | 1 | Shift clock value driven when master |
| sck_oe | output | 1 | Output enable for the shift clock line |
| sck_in | input | 1 | Shift clock from the peer |

## Verification
Each check is timed in clock edges from the edge that takes the start write. The first falling edge of the shift clock appears one cycle after that write. Each later clock edge follows the one before it by exactly CLK_DIV/2 cycles. The completion pulse comes one cycle after the start plus 15*CLK_DIV/2 edges, and the bench samples on falling system-clock edges at those exact counts. In external mode, each `sck_in` edge takes three cycles through the synchroniser and edge detect before it acts. For that reason the bench holds every phase for many cycles before it reads `ser_out`, and it looks for completion four cycles after the final rising edge.

// File: rtl/link_pkg.sv
package link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE          = 3'd0,
        ST_INT_LOW       = 3'd1,
        ST_INT_HIGH      = 3'd2,
        ST_EXT_WAIT_FALL = 3'd3,
        ST_EXT_WAIT_RISE = 3'd4
    } link_state_t;

    localparam int CTRL_START_BIT = 7;
    localparam int CTRL_SRC_BIT   = 0;

endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= INIT;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[i] <= INIT;
                    else        pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/link_half_timer.sv
module link_half_timer #(
    parameter int HALF = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/link_shift_reg.sv
module link_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             drive_en,
    input  logic             shift_en,
    input  logic             sin,
    output logic [WIDTH-1:0] data_q,
    output logic             sout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            sout   <= 1'b1;
        end else begin
            if (load_en)       data_q <= load_val;
            else if (shift_en) data_q <= {data_q[WIDTH-2:0], sin};
            if (drive_en)      sout   <= data_q[WIDTH-1];
        end
    end
endmodule

// File: rtl/link_fsm.sv
module link_fsm
    import link_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_en,
    input  logic ctrl_start,
    input  logic ctrl_src,
    input  logic half_tick,
    input  logic sck_sync,
    output logic busy,
    output logic xfer_irq,
    output logic clk_internal,
    output logic sck_out,
    output logic sck_oe,
    output logic drive_en,
    output logic shift_en,
    output logic timer_clr
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;

    link_state_t       state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic              sck_prev_q;
    logic              irq_q;
    logic              src_q;
    logic              ext_rise, ext_fall, last_bit, start_req, idle;

    assign idle      = (state_q == ST_IDLE);
    assign ext_rise  = sck_sync & ~sck_prev_q;
    assign ext_fall  = ~sck_sync & sck_prev_q;
    assign last_bit  = (bit_q == CNT_W'(WIDTH - 1));
    assign start_req = ctrl_wr_en && ctrl_start && idle;

    // Next state and shift strobes
    always_comb begin
        state_d  = state_q;
        drive_en = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    if (ctrl_src) begin
                        state_d  = ST_INT_LOW;
                        drive_en = 1'b1;
                    end else begin
                        state_d  = ST_EXT_WAIT_FALL;
                    end
                end
            end
            ST_INT_LOW: begin
                if (half_tick) begin
                    shift_en = 1'b1;
                    state_d  = last_bit ? ST_IDLE : ST_INT_HIGH;
                end
            end
            ST_INT_HIGH: begin
                if (half_tick) begin
                    drive_en = 1'b1;
                    state_d  = ST_INT_LOW;
                end
            end
            ST_EXT_WAIT_FALL: begin
                if (ext_fall) begin
                    drive_en = 1'b1;
                    state_d  = ST_EXT_WAIT_RISE;
                end
            end
            ST_EXT_WAIT_RISE: begin
                if (ext_rise) begin
                    shift_en = 1'b1;
                    state_d  = last_bit ? ST_IDLE : ST_EXT_WAIT_FALL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_q      <= '0;
            sck_prev_q <= 1'b1;
            irq_q      <= 1'b0;
            src_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            sck_prev_q <= sck_sync;
            irq_q      <= shift_en && last_bit;
            if (start_req)     bit_q <= '0;
            else if (shift_en) bit_q <= bit_q + 1'b1;
            if (ctrl_wr_en && idle) src_q <= ctrl_src;
        end
    end

    // Outputs
    always_comb begin
        busy         = !idle;
        xfer_irq     = irq_q;
        clk_internal = src_q;
        sck_out      = (state_q != ST_INT_LOW);
        sck_oe       = (state_q == ST_INT_LOW) || (state_q == ST_INT_HIGH);
        timer_clr    = idle || (state_d != state_q);
    end
endmodule

// File: rtl/link_shift_port.sv
module link_shift_port
    import link_pkg::*;
#(
    parameter int CLK_DIV     = 512,
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr_en,
    input  logic [WIDTH-1:0] data_wr,
    input  logic             ctrl_wr_en,
    input  logic [7:0]       ctrl_wr,
    output logic [WIDTH-1:0] data_q,
    output logic             busy,
    output logic             clk_internal,
    output logic             xfer_irq,
    output logic             ser_out,
    input  logic             ser_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             sck_in
);
    localparam int HALF = CLK_DIV / 2;

    logic sck_sync, sin_sync, half_tick, timer_clr, drive_en, shift_en;

    link_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_sync)
    );

    link_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sin_sync (
        .clk(clk), .rst_n(rst_n), .d(ser_in), .q(sin_sync)
    );

    link_half_timer #(.HALF(HALF)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr), .tick(half_tick)
    );

    link_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr_en   (ctrl_wr_en),
        .ctrl_start   (ctrl_wr[CTRL_START_BIT]),
        .ctrl_src     (ctrl_wr[CTRL_SRC_BIT]),
        .half_tick    (half_tick),
        .sck_sync     (sck_sync),
        .busy         (busy),
        .xfer_irq     (xfer_irq),
        .clk_internal (clk_internal),
        .sck_out      (sck_out),
        .sck_oe       (sck_oe),
        .drive_en     (drive_en),
        .shift_en     (shift_en),
        .timer_clr    (timer_clr)
    );

    link_shift_reg #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (data_wr_en && !busy),
        .load_val (data_wr),
        .drive_en (drive_en),
        .shift_en (shift_en),
        .sin      (sin_sync),
        .data_q   (data_q),
        .sout     (ser_out)
    );
endmodule

// File: rtl/link_shift_port_chk.sv
module link_shift_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr_en,
    input logic             start_bit,
    input logic             busy,
    input logic             xfer_irq,
    input logic             ser_out,
    input logic             sck_out,
    input logic             sck_oe,
    input logic [WIDTH-1:0] data_q
);
    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_en && start_bit && !busy) |=> busy);

    assert_oe_within_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sck_oe |-> busy);

    assert_clock_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> sck_out);

    assert_sout_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !$stable(ser_out)) |-> $fell(sck_out));

    assert_shift_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !$stable(data_q)) |-> $rose(sck_out));

    assert_irq_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq |-> (!busy && $past(busy)));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq |=> !xfer_irq);
endmodule

bind link_shift_port link_shift_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr_en (ctrl_wr_en),
    .start_bit  (ctrl_wr[7]),
    .busy       (busy),
    .xfer_irq   (xfer_irq),
    .ser_out    (ser_out),
    .sck_out    (sck_out),
    .sck_oe     (sck_oe),
    .data_q     (data_q)
);

// File: tb/sim_link_shift_port.sv
`timescale 1ns/1ps
module sim_link_shift_port;
    localparam int CLK_DIV = 512;
    localparam int HALF    = CLK_DIV / 2;
    localparam int EH      = 16;
    localparam int NVEC    = 6;
    // {byte sent by port, byte sent by peer}
    localparam logic [15:0] VEC [NVEC] = '{
        16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr_en = 1'b0;
    logic [7:0] data_wr = 8'h00;
    logic       ctrl_wr_en = 1'b0;
    logic [7:0] ctrl_wr = 8'h00;
    logic [7:0] data_q;
    logic       busy, clk_internal, xfer_irq, ser_out, sck_out, sck_oe;
    logic       ser_in = 1'b1;
    logic       sck_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_shift_port #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .data_wr_en(data_wr_en), .data_wr(data_wr),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr(ctrl_wr), .data_q(data_q), .busy(busy),
        .clk_internal(clk_internal), .xfer_irq(xfer_irq), .ser_out(ser_out),
        .ser_in(ser_in), .sck_out(sck_out), .sck_oe(sck_oe), .sck_in(sck_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_data(input logic [7:0] v);
        @(negedge clk); data_wr_en = 1'b1; data_wr = v;
        @(negedge clk); data_wr_en = 1'b0;
    endtask

    task automatic run_internal(input logic [7:0] tx, input logic [7:0] peer,
                                input bit present, input bit poke);
        logic [7:0] cap = 8'h00;
        logic [7:0] exp_rx;
        int falls = 0, rises = 0, bad_half = 0, bad_oe = 0;
        int irq_t = -1, last_edge = 0, t = 0;
        logic prev = 1'b1;
        logic busy_at_irq = 1'b1;
        exp_rx = present ? peer : 8'hFF;
        ser_in = 1'b1;
        load_data(tx);
        chk(data_q == tx, "R2 data load", data_q, tx);
        @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr = 8'h81;
        while (irq_t < 0 && t < 20 * HALF) begin
            @(negedge clk);
            t++;
            if (t == 1) ctrl_wr_en = 1'b0;
            if (poke && t == 1000) begin
                data_wr_en = 1'b1; data_wr = ~tx; ctrl_wr_en = 1'b1; ctrl_wr = 8'h00;
            end
            if (poke && t == 1001) begin
                data_wr_en = 1'b0; ctrl_wr_en = 1'b0;
            end
            if (irq_t < 0 && sck_oe !== busy) bad_oe++;
            if (prev && !sck_out) begin
                if (falls > 0 && t - last_edge != HALF) bad_half++;
                last_edge = t;
                ser_in = present ? peer[7 - falls] : 1'b1;
                falls++;
            end
            if (!prev && sck_out) begin
                if (t - last_edge != HALF) bad_half++;
                last_edge = t;
                cap = {cap[6:0], ser_out};
                rises++;
            end
            prev = sck_out;
            if (xfer_irq) begin
                irq_t = t;
                busy_at_irq = busy;
            end
        end
        ser_in = 1'b1;
        chk(irq_t == 15 * HALF + 1, "R6 completion cycle", irq_t, 15 * HALF + 1);
        chk(busy_at_irq == 1'b0, "R6 busy clear at irq", busy_at_irq, 0);
        chk(falls == 8 && rises == 8, "R3 eight clock pulses", falls, 8);
        chk(bad_half == 0, "R3 half period length", bad_half, 0);
        chk(bad_oe == 0, "R3 oe tracks transfer", bad_oe, 0);
        chk(cap == tx, "R4 msb-first output", cap, tx);
        chk(data_q == exp_rx, present ? "R5 received byte" : "R7 no peer all ones",
            data_q, exp_rx);
        @(negedge clk);
        chk(xfer_irq == 1'b0, "R6 irq one cycle", xfer_irq, 0);
        repeat (50) @(negedge clk);
        chk(ser_out == tx[0], "R8 last bit held", ser_out, tx[0]);
        chk(sck_out == 1'b1 && sck_oe == 1'b0, "R3 idle clock high", {sck_out, sck_oe}, 2);
        if (poke) begin
            chk(clk_internal == 1'b1, "R10 ctrl write ignored", clk_internal, 1);
            chk(busy == 1'b0, "R10 no restart", busy, 0);
        end
    endtask

    task automatic run_external(input logic [7:0] tx, input logic [7:0] peer);
        logic [7:0] cap = 8'h00;
        int irqs = 0, bad_oe = 0;
        load_data(tx);
        @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr = 8'h80;
        @(negedge clk); ctrl_wr_en = 1'b0;
        chk(busy == 1'b1 && clk_internal == 1'b0, "R2 external start", {busy, clk_internal}, 2);
        repeat (300) @(negedge clk);
        chk(busy == 1'b1 && data_q == tx, "R9 waits for peer clock", busy, 1);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0; ser_in = peer[7 - i];
            for (int k = 0; k < EH; k++) begin
                @(negedge clk);
                if (sck_oe) bad_oe++;
                if (xfer_irq) irqs++;
            end
            cap = {cap[6:0], ser_out};
            if (i == 7) chk(busy == 1'b1, "R9 busy until eighth rise", busy, 1);
            sck_in = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (sck_oe) bad_oe++;
                if (xfer_irq) irqs++;
            end
            for (int k = 4; k < EH; k++) @(negedge clk);
        end
        ser_in = 1'b1;
        chk(busy == 1'b0 && irqs == 1, "R9 external completion", irqs, 1);
        chk(bad_oe == 0, "R9 clock not driven", bad_oe, 0);
        chk(cap == tx, "R9 R4 external output order", cap, tx);
        chk(data_q == peer, "R9 R5 external received byte", data_q, peer);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(data_q == 8'h00 && busy == 1'b0 && xfer_irq == 1'b0 && clk_internal == 1'b0,
            "R1 reset state", {data_q, busy, xfer_irq, clk_internal}, 0);
        chk(ser_out == 1'b1 && sck_out == 1'b1 && sck_oe == 1'b0, "R1 reset lines",
            {ser_out, sck_out, sck_oe}, 6);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NVEC; v++)
            run_internal(VEC[v][15:8], VEC[v][7:0], 1'b1, 1'b0);

        // R7: no peer, input floats high
        run_internal(8'h96, 8'h00, 1'b0, 1'b0);

        // R10: writes during a transfer are ignored
        run_internal(8'h3C, 8'h42, 1'b1, 1'b1);

        // R2: control write without the start bit does not start
        begin
            int lows = 0;
            load_data(8'h77);
            @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr = 8'h01;
            @(negedge clk); ctrl_wr_en = 1'b0;
            for (int k = 0; k < 600; k++) begin
                @(negedge clk);
                if (!sck_out || busy) lows++;
            end
            chk(lows == 0, "R2 no start without bit 7", lows, 0);
            chk(clk_internal == 1'b1 && data_q == 8'h77, "R2 source bit only", data_q, 8'h77);
        end

        run_external(8'hC6, 8'h39);
        run_external(8'h0F, 8'hF0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule